// File: doc/BRIEF.md
# Long-Word to Narrow-Port Bus Width Converter

This block joins a fixed 36-bit long-word interface to a narrow interface whose width is picked at run time. The narrow side can be 36 bits (no conversion), 18 bits (two halves per long word) or 9 bits (four quarters per long word). The choice comes from two static configuration inputs: a match enable and a half/quarter select. Two independent paths share that configuration. The splitting path takes long words in and hands out narrow pieces. The assembling path takes narrow pieces in and hands out long words. Both sides of both paths use a valid/ready handshake in one clock domain.

The order of the pieces inside a long word follows an endian choice that is captured while reset is asserted. With big-endian order, the most significant piece goes first. With little-endian order, the least significant piece goes first. The same order applies in both paths. Narrow pieces always sit in the low bits of the 36-bit narrow buses. On the outgoing narrow bus, the bits above the active width read as zero. On the incoming narrow bus, the bits above the active width are ignored.

Top module: `bus_match_conv`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `nw_out_valid` and `lw_out_valid` are 0, and `nw_in_ready` and `lw_in_ready` are 1.
- R2: With `cfg_match_en`=0 (long mode), each accepted long word appears as exactly one narrow transfer carrying all 36 bits, and each accepted narrow transfer becomes one long word.
- R3: With `cfg_match_en`=1 and `cfg_half_sel`=1 (half mode), each long word is carried as two 18-bit pieces on `nw_out_data[17:0]`, with `nw_out_data[35:18]` equal to 0.
- R4: With `cfg_match_en`=1 and `cfg_half_sel`=0 (quarter mode), each long word is carried as four 9-bit pieces on `nw_out_data[8:0]`, with `nw_out_data[35:9]` equal to 0.
- R5: In the splitting path, if `cfg_endian`=1 at reset, the pieces go out from most significant to least significant. If `cfg_endian`=0 at reset, they go out from least significant to most significant.
- R6: In the assembling path, the first accepted piece fills the most significant slot when `cfg_endian`=1 at reset and the least significant slot when it was 0. Bits of `nw_in_data` above the active piece width are ignored.
- R7: While `nw_out_valid`=1 and `nw_out_ready`=0, the next cycle keeps `nw_out_valid`=1 and the same `nw_out_data`.
- R8: `lw_out_valid` rises only after the last piece of a long word is accepted. While it is high, `nw_in_ready` is 0. While it is high and not accepted, `lw_out_data` holds.
- R9: A reset discards a partly assembled long word. The pieces that follow reset start a fresh long word.
- R10: `cfg_endian` is sampled only while `rst` is high. Changing it after reset does not change the piece order.
- R11: A new long word is accepted only when no pieces are pending, or in the same cycle that the last pending piece is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures `cfg_endian` |
| cfg_match_en | input | 1 | 0: narrow side is 36 bits; 1: narrow side is 18 or 9 bits (static) |
| cfg_half_sel | input | 1 | With match enabled, 1: 18-bit pieces, 0: 9-bit pieces (static) |
| cfg_endian | input | 1 | Sampled during reset; 1: most significant piece first |
| lw_in_data | input | 36 | Long word into the splitting path |
| lw_in_valid | input | 1 | Long word offered |
| lw_in_ready | output | 1 | Splitting path can take a long word |
| nw_out_data | output | 36 | Narrow piece out, right-aligned |
| nw_out_valid | output | 1 | Narrow piece offered |
| nw_out_ready | input | 1 | Receiver takes the narrow piece |
| nw_in_data | input | 36 | Narrow piece into the assembling path, right-aligned |
| nw_in_valid | input | 1 | Narrow piece offered |
| nw_in_ready | output | 1 | Assembling path can take a piece |
| lw_out_data | output | 36 | Assembled long word |
| lw_out_valid | output | 1 | Assembled long word offered |
| lw_out_ready | input | 1 | Receiver takes the long word |

## Verification
The bench builds the block with its package defaults: a 36-bit long word and a maximum of four slots, which gives 18-bit halves and 9-bit quarters. With these values, all three narrow widths and both piece orders can be reached in short runs. The valid and ready inputs are randomized on every handshake, so back-pressure lands on each piece position, including the cycle where a new long word is loaded while the last piece leaves. The upper bits of incoming narrow pieces carry random junk, and a reset is applied in the middle of an assembly.

// File: rtl/bm_pkg.sv
package bm_pkg;

    localparam int LW    = 36;
    localparam int SLOTS = 4;
    localparam int QW    = LW / SLOTS;
    localparam int HW    = LW / 2;
    localparam int CW    = $clog2(SLOTS);

    typedef logic [LW-1:0] lword_t;
    typedef logic [CW-1:0] slot_t;

    typedef enum logic [1:0] {
        BM_LONG    = 2'd0,
        BM_HALF    = 2'd1,
        BM_QUARTER = 2'd2
    } bm_mode_e;

    typedef struct packed {
        lword_t data;
        slot_t  seq;
        logic   live;
    } bm_hold_t;

    function automatic bm_mode_e decode_mode(input logic match_en, input logic half_sel);
        if (!match_en)
            return BM_LONG;
        return half_sel ? BM_HALF : BM_QUARTER;
    endfunction

    function automatic slot_t final_seq(input bm_mode_e m);
        case (m)
            BM_HALF:    return slot_t'(1);
            BM_QUARTER: return slot_t'(SLOTS - 1);
            default:    return slot_t'(0);
        endcase
    endfunction

    function automatic slot_t slot_of(input slot_t seq, input slot_t last, input logic big);
        return big ? slot_t'(last - seq) : seq;
    endfunction

    function automatic lword_t pick_piece(input lword_t w, input bm_mode_e m, input slot_t s);
        lword_t r;
        r = '0;
        case (m)
            BM_HALF:    r[HW-1:0] = w[int'(s[0]) * HW +: HW];
            BM_QUARTER: r[QW-1:0] = w[int'(s) * QW +: QW];
            default:    r = w;
        endcase
        return r;
    endfunction

    function automatic lword_t place_piece(input lword_t acc, input bm_mode_e m,
                                           input slot_t s, input lword_t p);
        lword_t r;
        r = acc;
        case (m)
            BM_HALF:    r[int'(s[0]) * HW +: HW] = p[HW-1:0];
            BM_QUARTER: r[int'(s) * QW +: QW]    = p[QW-1:0];
            default:    r = p;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bm_cfg_latch.sv
module bm_cfg_latch
    import bm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     match_en,
    input  logic     half_sel,
    input  logic     endian_sel,
    output bm_mode_e mode,
    output slot_t    last_seq,
    output logic     big_endian
);
    logic big_q;

    always_ff @(posedge clk) begin
        if (rst)
            big_q <= endian_sel;
    end

    always_comb begin
        mode       = decode_mode(match_en, half_sel);
        last_seq   = final_seq(mode);
        big_endian = big_q;
    end
endmodule

// File: rtl/bm_splitter.sv
module bm_splitter
    import bm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bm_mode_e mode,
    input  slot_t    last_seq,
    input  logic     big_endian,
    input  lword_t   in_data,
    input  logic     in_valid,
    output logic     in_ready,
    output lword_t   out_data,
    output logic     out_valid,
    input  logic     out_ready
);
    bm_hold_t st;
    logic     at_last;
    logic     out_fire;
    logic     take_in;

    always_comb begin
        at_last   = (st.seq == last_seq);
        out_fire  = st.live && out_ready;
        in_ready  = !st.live || (out_ready && at_last);
        take_in   = in_valid && in_ready;
        out_valid = st.live;
        out_data  = pick_piece(st.data, mode, slot_of(st.seq, last_seq, big_endian));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.live <= 1'b0;
            st.seq  <= '0;
            st.data <= '0;
        end else if (take_in) begin
            st.live <= 1'b1;
            st.seq  <= '0;
            st.data <= in_data;
        end else if (out_fire) begin
            if (at_last) begin
                st.live <= 1'b0;
                st.seq  <= '0;
            end else begin
                st.seq  <= st.seq + slot_t'(1);
            end
        end
    end
endmodule

// File: rtl/bm_assembler.sv
module bm_assembler
    import bm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bm_mode_e mode,
    input  slot_t    last_seq,
    input  logic     big_endian,
    input  lword_t   in_data,
    input  logic     in_valid,
    output logic     in_ready,
    output lword_t   out_data,
    output logic     out_valid,
    input  logic     out_ready
);
    bm_hold_t st;
    logic     fire;

    always_comb begin
        in_ready  = !st.live;
        fire      = in_valid && !st.live;
        out_valid = st.live;
        out_data  = st.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.live <= 1'b0;
            st.seq  <= '0;
            st.data <= '0;
        end else begin
            if (fire) begin
                st.data <= place_piece(st.data, mode,
                                       slot_of(st.seq, last_seq, big_endian), in_data);
                if (st.seq == last_seq) begin
                    st.seq  <= '0;
                    st.live <= 1'b1;
                end else begin
                    st.seq  <= st.seq + slot_t'(1);
                end
            end
            if (st.live && out_ready)
                st.live <= 1'b0;
        end
    end
endmodule

// File: rtl/bus_match_conv.sv
module bus_match_conv
    import bm_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_match_en,
    input  logic         cfg_half_sel,
    input  logic         cfg_endian,
    input  logic [LW-1:0] lw_in_data,
    input  logic         lw_in_valid,
    output logic         lw_in_ready,
    output logic [LW-1:0] nw_out_data,
    output logic         nw_out_valid,
    input  logic         nw_out_ready,
    input  logic [LW-1:0] nw_in_data,
    input  logic         nw_in_valid,
    output logic         nw_in_ready,
    output logic [LW-1:0] lw_out_data,
    output logic         lw_out_valid,
    input  logic         lw_out_ready
);
    bm_mode_e mode;
    slot_t    last_seq;
    logic     big_endian;

    bm_cfg_latch u_cfg (
        .clk        (clk),
        .rst        (rst),
        .match_en   (cfg_match_en),
        .half_sel   (cfg_half_sel),
        .endian_sel (cfg_endian),
        .mode       (mode),
        .last_seq   (last_seq),
        .big_endian (big_endian)
    );

    bm_splitter u_split (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .last_seq   (last_seq),
        .big_endian (big_endian),
        .in_data    (lw_in_data),
        .in_valid   (lw_in_valid),
        .in_ready   (lw_in_ready),
        .out_data   (nw_out_data),
        .out_valid  (nw_out_valid),
        .out_ready  (nw_out_ready)
    );

    bm_assembler u_asm (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .last_seq   (last_seq),
        .big_endian (big_endian),
        .in_data    (nw_in_data),
        .in_valid   (nw_in_valid),
        .in_ready   (nw_in_ready),
        .out_data   (lw_out_data),
        .out_valid  (lw_out_valid),
        .out_ready  (lw_out_ready)
    );
endmodule

// File: rtl/bm_conv_checker.sv
module bm_conv_checker (
    input logic        clk,
    input logic        rst,
    input logic        cfg_match_en,
    input logic        cfg_half_sel,
    input logic        lw_in_valid,
    input logic        lw_in_ready,
    input logic [35:0] nw_out_data,
    input logic        nw_out_valid,
    input logic        nw_out_ready,
    input logic        nw_in_ready,
    input logic [35:0] lw_out_data,
    input logic        lw_out_valid,
    input logic        lw_out_ready
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!nw_out_valid && !lw_out_valid && nw_in_ready && lw_in_ready));

    a_r3_half_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (nw_out_valid && cfg_match_en && cfg_half_sel) |-> (nw_out_data[35:18] == 18'd0));

    a_r4_quarter_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (nw_out_valid && cfg_match_en && !cfg_half_sel) |-> (nw_out_data[35:9] == 27'd0));

    a_r7_hold_narrow_out: assert property (@(posedge clk) disable iff (rst)
        (nw_out_valid && !nw_out_ready) |=> (nw_out_valid && $stable(nw_out_data)));

    a_r8_block_while_full: assert property (@(posedge clk) disable iff (rst)
        lw_out_valid |-> !nw_in_ready);

    a_r8_hold_long_out: assert property (@(posedge clk) disable iff (rst)
        (lw_out_valid && !lw_out_ready) |=> (lw_out_valid && $stable(lw_out_data)));

    a_r11_no_early_load: assert property (@(posedge clk) disable iff (rst)
        (lw_in_valid && lw_in_ready) |-> (!nw_out_valid || nw_out_ready));
endmodule

bind bus_match_conv bm_conv_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_match_en (cfg_match_en),
    .cfg_half_sel (cfg_half_sel),
    .lw_in_valid  (lw_in_valid),
    .lw_in_ready  (lw_in_ready),
    .nw_out_data  (nw_out_data),
    .nw_out_valid (nw_out_valid),
    .nw_out_ready (nw_out_ready),
    .nw_in_ready  (nw_in_ready),
    .lw_out_data  (lw_out_data),
    .lw_out_valid (lw_out_valid),
    .lw_out_ready (lw_out_ready)
);

// File: tb/bus_match_conv_test.sv
module bus_match_conv_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_match_en = 1'b0;
    logic        cfg_half_sel = 1'b0;
    logic        cfg_endian = 1'b0;
    logic [35:0] lw_in_data = '0;
    logic        lw_in_valid = 1'b0;
    logic        lw_in_ready;
    logic [35:0] nw_out_data;
    logic        nw_out_valid;
    logic        nw_out_ready = 1'b0;
    logic [35:0] nw_in_data = '0;
    logic        nw_in_valid = 1'b0;
    logic        nw_in_ready;
    logic [35:0] lw_out_data;
    logic        lw_out_valid;
    logic        lw_out_ready = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bus_match_conv uut (
        .clk(clk), .rst(rst),
        .cfg_match_en(cfg_match_en), .cfg_half_sel(cfg_half_sel), .cfg_endian(cfg_endian),
        .lw_in_data(lw_in_data), .lw_in_valid(lw_in_valid), .lw_in_ready(lw_in_ready),
        .nw_out_data(nw_out_data), .nw_out_valid(nw_out_valid), .nw_out_ready(nw_out_ready),
        .nw_in_data(nw_in_data), .nw_in_valid(nw_in_valid), .nw_in_ready(nw_in_ready),
        .lw_out_data(lw_out_data), .lw_out_valid(lw_out_valid), .lw_out_ready(lw_out_ready)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state, set from the bench's own settings
    int             m_n   = 1;
    bit             m_big = 1'b0;
    string          mode_tag = "R2";
    string          extra_tag = "";
    logic [35:0]    exp_p[$];
    logic [35:0]    exp_w[$];
    logic [35:0]    m_acc = '0;
    int             m_cnt = 0;
    bit             done_a = 1'b0;
    bit             done_b = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [35:0] act,
                       input logic [35:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [35:0] pmask(input int n);
        if (n == 1) return '1;
        return (36'd1 << (36 / n)) - 36'd1;
    endfunction

    function automatic int slot_at(input int i, input int n, input bit big);
        return big ? (n - 1 - i) : i;
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst) begin
            exp_p.delete();
            exp_w.delete();
            m_acc = '0;
            m_cnt = 0;
        end else begin
            chk(nw_out_valid == (exp_p.size() > 0),
                $sformatf("%s R11 narrow valid%s", mode_tag, extra_tag),
                36'(nw_out_valid), 36'(exp_p.size() > 0));
            if (nw_out_valid && exp_p.size() > 0)
                chk(nw_out_data == exp_p[0],
                    $sformatf("%s R5 R10 piece%s", mode_tag, extra_tag), nw_out_data, exp_p[0]);
            chk(lw_out_valid == (exp_w.size() > 0),
                $sformatf("R8 long valid%s", extra_tag), 36'(lw_out_valid), 36'(exp_w.size() > 0));
            chk(nw_in_ready == (exp_w.size() == 0),
                $sformatf("R8 piece ready%s", extra_tag), 36'(nw_in_ready), 36'(exp_w.size() == 0));
            if (lw_out_valid && exp_w.size() > 0)
                chk(lw_out_data == exp_w[0],
                    $sformatf("%s R6 R10 assembled%s", mode_tag, extra_tag), lw_out_data, exp_w[0]);

            if (nw_out_valid && nw_out_ready && exp_p.size() > 0)
                void'(exp_p.pop_front());
            if (lw_in_valid && lw_in_ready)
                for (int i = 0; i < m_n; i++)
                    exp_p.push_back((lw_in_data >> (slot_at(i, m_n, m_big) * (36 / m_n)))
                                    & pmask(m_n));
            if (lw_out_valid && lw_out_ready && exp_w.size() > 0)
                void'(exp_w.pop_front());
            if (nw_in_valid && nw_in_ready) begin
                int sh;
                sh = slot_at(m_cnt, m_n, m_big) * (36 / m_n);
                m_acc = (m_acc & ~(pmask(m_n) << sh)) | ((nw_in_data & pmask(m_n)) << sh);
                m_cnt++;
                if (m_cnt == m_n) begin
                    exp_w.push_back(m_acc);
                    m_cnt = 0;
                end
            end
        end
    end

    task automatic do_reset(input bit me, input bit half, input bit big);
        @(posedge clk); #1;
        rst = 1'b1;
        lw_in_valid = 1'b0;
        nw_in_valid = 1'b0;
        cfg_match_en = me;
        cfg_half_sel = half;
        cfg_endian = big;
        m_n = !me ? 1 : (half ? 2 : 4);
        m_big = big;
        mode_tag = !me ? "R2" : (half ? "R3" : "R4");
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        cfg_endian = ~big;   // R10: later changes must not matter
        @(negedge clk);
        chk(!nw_out_valid && !lw_out_valid && nw_in_ready && lw_in_ready,
            "R1 reset state", {32'd0, nw_out_valid, lw_out_valid, nw_in_ready, lw_in_ready},
            36'b0011);
    endtask

    task automatic send_long(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(posedge clk); #1;
            lw_in_valid = ($urandom % 4) != 0;
            lw_in_data = 36'({$urandom, $urandom});
            while (!lw_in_valid) begin
                @(posedge clk); #1;
                lw_in_valid = ($urandom % 3) != 0;
            end
            @(negedge clk);
            while (!lw_in_ready) @(negedge clk);
            @(posedge clk); #1;
            lw_in_valid = 1'b0;
        end
        done_a = 1'b1;
    endtask

    task automatic send_pieces(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(posedge clk); #1;
            nw_in_data = 36'({$urandom, $urandom});   // junk above the piece width (R6)
            nw_in_valid = ($urandom % 4) != 0;
            while (!nw_in_valid) begin
                @(posedge clk); #1;
                nw_in_valid = ($urandom % 3) != 0;
            end
            @(negedge clk);
            while (!nw_in_ready) @(negedge clk);
            @(posedge clk); #1;
            nw_in_valid = 1'b0;
        end
        done_b = 1'b1;
    endtask

    task automatic sink();
        while (!(done_a && done_b && exp_p.size() == 0 && exp_w.size() == 0)) begin
            @(posedge clk); #1;
            nw_out_ready = ($urandom % 4) != 0;
            lw_out_ready = ($urandom % 3) != 0;
        end
    endtask

    task automatic run_phase(input int longs, input int pieces);
        done_a = 1'b0;
        done_b = 1'b0;
        fork
            send_long(longs);
            send_pieces(pieces);
            sink();
        join
    endtask

    initial begin
        do_reset(1'b0, 1'b0, 1'b0); run_phase(12, 12);
        do_reset(1'b0, 1'b1, 1'b1); run_phase(12, 12);
        do_reset(1'b1, 1'b1, 1'b1); run_phase(12, 24);
        do_reset(1'b1, 1'b1, 1'b0); run_phase(12, 24);
        do_reset(1'b1, 1'b0, 1'b1); run_phase(12, 48);
        do_reset(1'b1, 1'b0, 1'b0); run_phase(12, 48);
        // R9: leave a partial quarter-mode word, then reset and start over
        do_reset(1'b1, 1'b0, 1'b0); run_phase(0, 3);
        extra_tag = " R9";
        do_reset(1'b1, 1'b0, 1'b1); run_phase(8, 32);
        do_reset(1'b1, 1'b1, 1'b0); run_phase(8, 16);
        repeat (4) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule